// File: doc/BRIEF.md
# Shared Interrupt Vector Register for Two Serial Units

This block holds one programmable interrupt vector that two serial sub-units share. One is a synchronous (clocked) serial unit and the other is an asynchronous serial unit. Software writes a base vector and an interrupt level through a 16-bit register port with byte enables. The block latches a request pulse from either sub-unit. While any request is pending and the level is non-zero, it presents the level on `irq_level`.

When the system acknowledges, the block drives an 8-bit vector on a bus with an output enable. Bits 7:1 come from the programmed register. Bit 0 names the sub-unit being served, so the two sub-units land on adjacent exception vectors.

If both sub-units are pending at one acknowledge, the synchronous unit is served first and the other request waits for the next acknowledge. A level of zero masks both sources.

Top module: `irq_vec_share`

## Requirements
- R1: After a synchronous reset, a register read returns 0x000F: vector 0x0F and level 0. `irq_level` is 0 and `vec_oe` is low.
- R2: A write with `wr_be[0]` set updates vector bits 7:1 from `wr_data[7:1]`. A write with `wr_be[1]` set updates the level from `wr_data[10:8]`. A byte whose enable is clear keeps its value. Read bits 15:11 are always 0.
- R3: Writes to vector bit 0 have no effect, and bit 0 of every read returns 1.
- R4: In the cycle after an accepted `ack` pulse, `vec_out[7:1]` equals the programmed vector bits 7:1. `vec_out[0]` is 1 when the synchronous unit is served and 0 when the asynchronous unit is served.
- R5: If both sources are pending at an accepted `ack`, the synchronous unit is served and the asynchronous request stays pending for a later `ack`.
- R6: `vec_oe` is high only in the cycle that follows an accepted `ack` pulse. While `vec_oe` is low, `vec_out` is 0.
- R7: While the level is 0, `irq_level` stays 0 and `ack` is ignored: no vector is driven and pending requests are kept. Once a non-zero level is written, those requests are presented.
- R8: A request pulse on `req_sync` or `req_async` is latched. Two cycles after the pulse, `irq_level` shows the programmed level, and it returns to 0 once nothing is pending.
- R9: Read data is registered: `rd_data` shows the register contents in the cycle after `rd_en` and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 2 | Byte enables: bit 0 for the low byte, bit 1 for the high byte |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 16 | Registered read data |
| req_sync | input | 1 | Request pulse from the synchronous serial unit |
| req_async | input | 1 | Request pulse from the asynchronous serial unit |
| ack | input | 1 | Interrupt-acknowledge strobe (one-cycle pulse) |
| irq_level | output | 3 | Presented interrupt level, 0 when nothing is pending or when masked |
| vec_oe | output | 1 | Output enable for the vector bus |
| vec_out | output | 8 | Acknowledge vector |

## Verification
Several rules are checked by the bound checker on every clock cycle:
- bit 0 of read data is always 1;
- `vec_oe` never rises without a preceding `ack`, and `vec_out` is zero while it is low;
- `ack` is ignored while the level is 0;
- the upper vector bits follow the register;
- a double request serves the synchronous unit first and keeps the other request pending.

Only the bench's scenarios can show the rest. These are the byte-enable merging of writes, the reset read value, the exact sequence of served vectors across successive acknowledges, and that masked requests survive until a level is written.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  typedef enum logic {
    SRC_ASYNC = 1'b0,
    SRC_SYNC  = 1'b1
  } src_e;

  localparam int IDX_ASYNC = 0;
  localparam int IDX_SYNC  = 1;
  localparam int NUM_SRC   = 2;
endpackage

// File: rtl/irqv_regs.sv
module irqv_regs #(
  parameter int REG_W = 16,
  parameter int VEC_W = 8,
  parameter int LVL_W = 3,
  parameter logic [VEC_W-1:0] VEC_RST = 8'h0F,
  localparam int BE_W = REG_W / 8,
  localparam int LVL_LSB = VEC_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [BE_W-1:0]    wr_be,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               rd_en,
  output logic [REG_W-1:0]   rd_data,
  output logic [VEC_W-1:1]   vec_hi,
  output logic [LVL_W-1:0]   lvl
);
  logic [REG_W-1:0] rd_view;
  logic             unused_wbits;

  // bit 0 and the bits above the level field are not storage
  assign unused_wbits = ^{wr_data[0], wr_data[REG_W-1:LVL_LSB+LVL_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_hi <= VEC_RST[VEC_W-1:1];
      lvl    <= '0;
    end else if (wr_en) begin
      if (wr_be[0]) vec_hi <= wr_data[VEC_W-1:1];
      if (wr_be[1]) lvl    <= wr_data[LVL_LSB +: LVL_W];
    end
  end

  always_comb begin
    rd_view = '0;
    rd_view[VEC_W-1:1] = vec_hi;
    rd_view[0] = 1'b1;
    rd_view[LVL_LSB +: LVL_W] = lvl;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_view;
  end
endmodule

// File: rtl/irqv_arb.sv
module irqv_arb
  import irqv_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               req_sync,
  input  logic               req_async,
  input  logic               take,
  output logic [NUM_SRC-1:0] pend,
  output src_e               sel
);
  logic [NUM_SRC-1:0] set_v;
  logic [NUM_SRC-1:0] clr_v;

  always_comb begin
    set_v = '0;
    set_v[IDX_SYNC]  = req_sync;
    set_v[IDX_ASYNC] = req_async;
  end

  // fixed priority: synchronous unit first
  assign sel = pend[IDX_SYNC] ? SRC_SYNC : SRC_ASYNC;

  always_comb begin
    clr_v = '0;
    if (take) begin
      if (sel == SRC_SYNC) clr_v[IDX_SYNC]  = 1'b1;
      else                 clr_v[IDX_ASYNC] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr_v) | set_v;
  end
endmodule

// File: rtl/irqv_drive.sv
module irqv_drive
  import irqv_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             present,
  input  src_e             sel,
  input  logic [VEC_W-1:1] vec_hi,
  input  logic [LVL_W-1:0] lvl,
  output logic             vec_oe,
  output logic [VEC_W-1:0] vec_out,
  output logic [LVL_W-1:0] irq_level
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vec_oe    <= 1'b0;
      vec_out   <= '0;
      irq_level <= '0;
    end else begin
      vec_oe    <= take;
      vec_out   <= take ? {vec_hi, sel} : '0;
      irq_level <= present ? lvl : '0;
    end
  end
endmodule

// File: rtl/irq_vec_share.sv
module irq_vec_share
  import irqv_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int VEC_W = 8,
  parameter int LVL_W = 3,
  localparam int BE_W = REG_W / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [BE_W-1:0]  wr_be,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [REG_W-1:0] rd_data,
  input  logic             req_sync,
  input  logic             req_async,
  input  logic             ack,
  output logic [LVL_W-1:0] irq_level,
  output logic             vec_oe,
  output logic [VEC_W-1:0] vec_out
);
  logic [VEC_W-1:1]   vec_hi;
  logic [LVL_W-1:0]   lvl_q;
  logic [NUM_SRC-1:0] pend;
  src_e               sel;
  logic               present;
  logic               take;

  assign present = (|pend) && (lvl_q != '0);
  assign take    = ack && present;

  irqv_regs #(.REG_W(REG_W), .VEC_W(VEC_W), .LVL_W(LVL_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .vec_hi(vec_hi), .lvl(lvl_q)
  );

  irqv_arb u_arb (
    .clk(clk), .rst(rst), .req_sync(req_sync), .req_async(req_async),
    .take(take), .pend(pend), .sel(sel)
  );

  irqv_drive #(.VEC_W(VEC_W), .LVL_W(LVL_W)) u_drive (
    .clk(clk), .rst(rst), .take(take), .present(present), .sel(sel),
    .vec_hi(vec_hi), .lvl(lvl_q), .vec_oe(vec_oe), .vec_out(vec_out),
    .irq_level(irq_level)
  );
endmodule

// File: rtl/irqv_chk.sv
module irqv_chk
  import irqv_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int VEC_W = 8,
  parameter int LVL_W = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               ack,
  input logic               rd_en,
  input logic [REG_W-1:0]   rd_data,
  input logic               vec_oe,
  input logic [VEC_W-1:0]   vec_out,
  input logic [LVL_W-1:0]   irq_level,
  input logic [NUM_SRC-1:0] pend,
  input logic [LVL_W-1:0]   lvl,
  input logic [VEC_W-1:1]   vec_hi
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!vec_oe && irq_level == '0));

  p_rd_bit0_r3: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && !rst) |-> rd_data[0]);

  p_upper_bits_r4: assert property (@(posedge clk) disable iff (rst)
    (ack && lvl != '0 && pend != '0) |=> (vec_oe && vec_out[VEC_W-1:1] == $past(vec_hi)));

  p_sync_first_r5: assert property (@(posedge clk) disable iff (rst)
    (ack && lvl != '0 && pend == 2'b11) |=> (vec_oe && vec_out[0] && pend[IDX_ASYNC]));

  p_oe_after_ack_r6: assert property (@(posedge clk) disable iff (rst)
    vec_oe |-> $past(ack));

  p_idle_bus_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !vec_oe |-> (vec_out == '0));

  p_masked_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (ack && lvl == '0) |=> !vec_oe);
endmodule

bind irq_vec_share irqv_chk #(.REG_W(REG_W), .VEC_W(VEC_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .ack(ack), .rd_en(rd_en), .rd_data(rd_data),
  .vec_oe(vec_oe), .vec_out(vec_out), .irq_level(irq_level),
  .pend(pend), .lvl(lvl_q), .vec_hi(vec_hi)
);

// File: tb/irq_vec_share_bench.sv
module irq_vec_share_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_be = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        req_sync = 1'b0;
  logic        req_async = 1'b0;
  logic        ack = 1'b0;
  logic [2:0]  irq_level;
  logic        vec_oe;
  logic [7:0]  vec_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  irq_vec_share u_irq_vec_share (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .req_sync(req_sync), .req_async(req_async),
    .ack(ack), .irq_level(irq_level), .vec_oe(vec_oe), .vec_out(vec_out)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_write(input logic [1:0] be, input logic [15:0] d);
    wr_en = 1'b1; wr_be = be; wr_data = d;
    step();
    wr_en = 1'b0; wr_be = '0; wr_data = '0;
  endtask

  task automatic do_read(input string req, input logic [15:0] exp);
    rd_en = 1'b1;
    step();
    rd_en = 1'b0;
    @(negedge clk);
    check(req, rd_data, exp);
    step();
  endtask

  task automatic pulse_req(input logic s, input logic a);
    req_sync = s; req_async = a;
    step();
    req_sync = 1'b0; req_async = 1'b0;
  endtask

  // driver: one ack pulse, expected vector pushed to the scoreboard
  task automatic do_ack(input bit expect_drive, input logic [7:0] exp, input string req);
    if (expect_drive) begin
      exp_q.push_back(exp);
      tag_q.push_back(req);
    end
    ack = 1'b1;
    step();
    ack = 1'b0;
    step();
  endtask

  task automatic level_check(input string req, input logic [2:0] exp);
    step();
    @(negedge clk);
    check(req, {13'd0, irq_level}, {13'd0, exp});
  endtask

  // monitor: compares every driven vector against the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (vec_oe) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R6/R7 unexpected vector actual=%h expected=none", vec_out);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (vec_out !== e) begin
            errors++;
            $display("FAIL %s vector actual=%h expected=%h", t, vec_out, e);
          end
        end
      end else if (vec_out !== 8'h00) begin
        checks++;
        errors++;
        $display("FAIL R6 idle bus actual=%h expected=00", vec_out);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all) actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    @(negedge clk);
    check("R1 oe", {15'd0, vec_oe}, 16'h0000);
    check("R1 level", {13'd0, irq_level}, 16'h0000);
    step();
    do_read("R1 reset read", 16'h000F);

    do_write(2'b01, 16'h0042);
    do_read("R3 bit0 forced", 16'h0043);
    do_write(2'b01, 16'hAA55);
    do_read("R2 low byte only", 16'h0055);
    do_write(2'b10, 16'hFF00);
    do_read("R2 level byte, upper zero", 16'h0755);
    do_write(2'b00, 16'hFFFF);
    do_read("R2 no enables", 16'h0755);
    do_write(2'b11, 16'h0380);
    do_read("R9 registered read", 16'h0381);
    @(negedge clk);
    check("R9 hold", rd_data, 16'h0381);

    pulse_req(1'b0, 1'b1);
    level_check("R8 level presented", 3'd3);
    do_ack(1'b1, 8'h80, "R4 async");
    level_check("R8 level cleared", 3'd0);

    pulse_req(1'b1, 1'b0);
    do_ack(1'b1, 8'h81, "R4 sync");

    pulse_req(1'b1, 1'b1);
    step();
    do_ack(1'b1, 8'h81, "R5 sync first");
    level_check("R5 async still pending", 3'd3);
    do_ack(1'b1, 8'h80, "R5 async second");
    level_check("R5 drained", 3'd0);

    do_write(2'b10, 16'h0000);
    pulse_req(1'b1, 1'b0);
    level_check("R7 masked level", 3'd0);
    do_ack(1'b0, 8'h00, "R7");
    @(negedge clk);
    check("R7 no drive", {15'd0, vec_oe}, 16'h0000);
    do_write(2'b10, 16'h0500);
    level_check("R7 pending kept", 3'd5);
    do_ack(1'b1, 8'h81, "R7 served after unmask");

    do_write(2'b01, 16'h00FE);
    pulse_req(1'b0, 1'b1);
    do_ack(1'b1, 8'hFE, "R4 new vector async");
    pulse_req(1'b1, 1'b0);
    do_ack(1'b1, 8'hFF, "R4 new vector sync");

    do_ack(1'b0, 8'h00, "R6 spurious");
    repeat (3) step();
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R4 missing vectors actual=%0d expected=0", exp_q.size());
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule